// File: doc/BRIEF.md
# Oversampled Serial Shift Transmitter

This block sends a parallel word out one bit at a time, paced by a slow clock that arrives from outside, while every data register runs on a fast local master clock. The only logic on the external clock is a single flop that inverts on each rising edge of that clock. The master domain samples this toggle through a short synchroniser chain. A two-state level tracker then turns each change of the synchronised toggle into a shift strobe that lasts one master cycle. The strobe advances a wide shift register, and the register's top bit drives the serial line.

A word is loaded by pulsing the load input for one master cycle, with the word on the parallel data input. No extra edge of the external clock is needed. The word then leaves most significant bit first, one bit for each rising edge of the external clock, with zeros filling in from the bottom. The level tracker has two states. LVL_LOW means the last synchronised toggle value seen was 0, and LVL_HIGH means it was 1. The transition LVL_LOW to LVL_HIGH happens when the synchronised toggle reads 1, and LVL_HIGH to LVL_LOW happens when it reads 0. Both transitions emit the strobe in the cycle where the tracker and the synchronised level disagree. Both states hold without a strobe otherwise.

Top module: `serclk_shift_tx`

## Requirements
- R1: While reset is low, and after its release for as long as no external rising edge and no load occur, the serial output stays 0. Reset does not cause a spurious shift: after a load that follows reset, the first external rising edge exposes bit DATA_W-2.
- R2: Each rising edge of the external clock causes exactly one shift. Falling edges of the external clock have no effect on the serial output.
- R3: The shift strobe is high for exactly one master cycle for each change of the synchronised toggle, in either direction.
- R4: A shift moves every bit one place toward the MSB (bit DATA_W-1) and puts 0 into bit 0. The serial output is bit DATA_W-1, so a loaded word leaves MSB first: after k shifts the output equals loaded bit DATA_W-1-k.
- R5: Load is synchronous. After a master cycle with load high, the register holds the parallel input, and the serial output shows its bit DATA_W-1.
- R6: If load and a shift strobe fall in the same master cycle, the load wins and that shift is lost.
- R7: With neither load nor strobe, the register and the serial output hold their values.
- R8: After DATA_W shifts the serial output is 0, and further shifts keep it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast master clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ext_sclk | input | 1 | Slow external shift clock, rising edge active |
| load | input | 1 | One-cycle parallel load request, master domain |
| load_data | input | DATA_W | Word to transmit |
| sout | output | 1 | Serial output, MSB of the shift register |

## Verification
The checker assumes that successive changes of the toggle are far enough apart in master cycles that each change passes through the synchroniser before the next one arrives. In practice this means the external clock runs several times slower than the master clock. It also assumes the external clock is idle while reset is asserted. The bench keeps every external rising edge at least eight master cycles from the next one, and holds the external clock low through reset. It places some edges on master falling edges and others at fractional offsets, so the phase between the two clocks varies. The collision case is built by timing a load to meet the strobe in the same cycle.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    // Level tracker states: last synchronised toggle level seen
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/sctx_toggle.sv
module sctx_toggle (
    input  logic ext_sclk,
    input  logic rst_n,
    output logic tgl_q
);

    // Only flop in the external domain; inverts on every rising edge
    always_ff @(posedge ext_sclk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= ~tgl_q;
        end
    end

endmodule

// File: rtl/sctx_sync.sv
module sctx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain_q[0] <= 1'b0;
                    end else begin
                        chain_q[0] <= d_async;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain_q[s] <= 1'b0;
                    end else begin
                        chain_q[s] <= chain_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sctx_edge_fsm.sv
module sctx_edge_fsm
    import sctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic strobe
);

    lvl_state_e state_q;
    lvl_state_e state_d;

    // State register: also serves as the history copy of the level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_in)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_in) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // Output decode: one-cycle strobe on either transition
    always_comb begin
        strobe = 1'b0;
        unique case (state_q)
            LVL_LOW:  strobe = lvl_in;
            LVL_HIGH: strobe = ~lvl_in;
            default:  strobe = 1'b0;
        endcase
    end

endmodule

// File: rtl/sctx_shreg.sv
module sctx_shreg #(
    parameter int WIDTH = 77
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             shift,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    // Load has priority over shift; zero fills bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_data;
        end else if (shift) begin
            q <= {q[TOP-1:0], 1'b0};
        end
    end

endmodule

// File: rtl/serclk_shift_tx.sv
module serclk_shift_tx #(
    parameter int DATA_W      = 77,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sclk,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              sout
);

    localparam int MSB = DATA_W - 1;

    logic              tgl_ext;
    logic              sync_lvl;
    logic              shift_stb;
    logic [DATA_W-1:0] sreg_q;

    sctx_toggle u_toggle (
        .ext_sclk (ext_sclk),
        .rst_n    (rst_n),
        .tgl_q    (tgl_ext)
    );

    sctx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (tgl_ext),
        .q_sync  (sync_lvl)
    );

    sctx_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (sync_lvl),
        .strobe (shift_stb)
    );

    sctx_shreg #(
        .WIDTH (DATA_W)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .shift     (shift_stb),
        .q         (sreg_q)
    );

    assign sout = sreg_q[MSB];

endmodule

// File: rtl/sctx_chk.sv
module sctx_chk #(
    parameter int W = 77
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic [W-1:0] load_data,
    input logic         strobe,
    input logic         lvl_sync,
    input logic [W-1:0] sreg
);

    // R3: strobe never lasts more than one cycle
    p_one_cycle_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R3: a change of the synchronised level yields a strobe in that cycle
    p_change_gives_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sync != $past(lvl_sync)) |-> strobe);

    // R4: shift moves toward MSB and zero-fills
    p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load) |=> (sreg == {$past(sreg[W-2:0]), 1'b0}));

    // R5, R6: load takes the parallel word whether or not a strobe is present
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sreg == $past(load_data)));

    // R7: nothing happens without load or strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !load) |=> $stable(sreg));

endmodule

bind serclk_shift_tx sctx_chk #(
    .W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .strobe    (shift_stb),
    .lvl_sync  (sync_lvl),
    .sreg      (sreg_q)
);

// File: tb/serclk_shift_tx_tb.sv
`timescale 1ns/100ps
module serclk_shift_tx_tb;

    localparam int W = 77;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_sclk = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_data = '0;
    logic         sout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    serclk_shift_tx #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sclk  (ext_sclk),
        .load      (load),
        .load_data (load_data),
        .sout      (sout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sout actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] pattern(input int f);
        logic [W-1:0] p;
        for (int i = 0; i < W; i++) begin
            case (f)
                0: p[i] = 1'b1;
                1: p[i] = i[0];
                default: p[i] = (((i * (2 * f + 3)) + f * 7) % 5) < 2;
            endcase
        end
        return p;
    endfunction

    task automatic do_load(input logic [W-1:0] d);
        @(negedge clk);
        load = 1'b1;
        load_data = d;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Edge aligned to a master falling edge; returns output before and after fall
    task automatic edge_aligned(output logic before_fall, output logic after_fall);
        @(negedge clk);
        ext_sclk = 1'b1;
        repeat (4) @(negedge clk);
        before_fall = sout;
        ext_sclk = 1'b0;
        repeat (4) @(negedge clk);
        after_fall = sout;
    endtask

    // Edge at a fractional phase relative to the master clock
    task automatic edge_async(input int k, output logic before_fall, output logic after_fall);
        real dly;
        dly = 0.3 + (k % 7) * 0.55;
        @(negedge clk);
        #(dly);
        ext_sclk = 1'b1;
        repeat (5) @(negedge clk);
        before_fall = sout;
        #(1.7);
        ext_sclk = 1'b0;
        repeat (4) @(negedge clk);
        after_fall = sout;
    endtask

    task automatic run_frame(input int f, input bit asyn);
        logic [W-1:0] d;
        logic b, a, exp;
        d = pattern(f);
        do_load(d);
        check("R5 load shows MSB", sout, d[W-1]);
        for (int k = 1; k <= W + 2; k++) begin
            if (asyn) edge_async(k, b, a);
            else      edge_aligned(b, a);
            exp = (k < W) ? d[W-1-k] : 1'b0;
            if (k < W) check("R4 MSB-first bit order", b, exp);
            else       check("R8 zero after full frame", b, exp);
            check("R2 falling edge ignored", a, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] da, db;
        logic b, a;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sout low in reset", sout, 1'b0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 sout low after reset", sout, 1'b0);

        // R1, R7: no spurious shift; hold while idle
        da = pattern(2);
        do_load(da);
        repeat (30) @(negedge clk);
        check("R7 hold while idle", sout, da[W-1]);
        edge_aligned(b, a);
        check("R1 first edge gives bit W-2", b, da[W-2]);
        repeat (25) @(negedge clk);
        check("R7 hold between edges", sout, da[W-2]);

        // R4/R5/R8/R2 across patterns and phases
        for (int f = 0; f < 8; f++) begin
            run_frame(f, f[0]);
        end

        // R6: load meets a strobe in the same cycle
        da = pattern(3);
        db = ~pattern(4);
        do_load(da);
        for (int k = 1; k <= 5; k++) edge_aligned(b, a);
        check("R4 five shifts before collision", sout, da[W-6]);
        @(negedge clk);
        ext_sclk = 1'b1;               // strobe active for the posedge two negedges on
        @(negedge clk);
        @(negedge clk);
        load = 1'b1;
        load_data = db;
        @(negedge clk);
        load = 1'b0;
        check("R6 load wins over shift", sout, db[W-1]);
        ext_sclk = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 colliding shift lost", sout, db[W-1]);
        edge_aligned(b, a);
        check("R6 next edge gives bit W-2", b, db[W-2]);

        // R3: a burst of edges at minimum spacing still yields one shift each
        for (int k = 3; k <= 10; k++) begin
            edge_aligned(b, a);
            check("R3 one shift per edge", b, db[W-k]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule